// File: doc/BRIEF.md
# RMS Zero-Level Mute Detector

This block watches a stream of loudness estimates, one 16-bit level word per audio channel, and decides per channel whether the output should be silenced. A hysteresis band keeps the decision from chattering. An unmuted channel goes quiet when its level sits under a low threshold. A muted channel only comes back when its level climbs over a separate, higher threshold. A run-length filter requires the condition to hold for a programmable number of consecutive samples before either transition is taken.

Both thresholds are loaded through one 16-bit field that is written as two bytes. A select input decides which threshold a write is aimed at. The upper byte is only staged. The full word is committed when the lower byte is written, so a threshold is never used while it is half updated. The most recent level sampled on any channel can be read back through a channel-select port.

Top module: `zl_mute_det`

## Requirements
- R1: While reset is active, and on the first cycle after it, every bit of `mute_o` is 1 and `rd_level` reads 0. The low threshold resets to `THR_LO_RST` (default 0x0100) and the high threshold resets to `THR_HI_RST` (default 0x0200).
- R2: A pulse on `thr_wr_hi` only stages `thr_byte` as the upper eight bits of a pending value. Neither threshold changes, and no mute decision changes, until a later `thr_wr_lo` pulse.
- R3: A pulse on `thr_wr_lo` commits {staged byte, `thr_byte`} in one cycle. The target is the low threshold when `thr_sel` is 1 and the high threshold when `thr_sel` is 0. The new value is used for samples taken from the next cycle onward.
- R4: An unmuted channel mutes once it has taken `run_len_m1`+1 consecutive valid samples whose level is strictly below the low threshold. `run_len_m1` ranges from 0 to 255, giving 1 to 256 samples. A level equal to the threshold does not count.
- R5: A muted channel unmutes once it has taken `run_len_m1`+1 consecutive valid samples whose level is strictly above the high threshold. A level equal to the threshold does not count.
- R6: A valid sample that does not meet the current condition clears that channel's run count. A cycle without a valid sample leaves the run count unchanged.
- R7: Each channel keeps its own mute state and run count. Bit c of `mute_o` changes only on the clock edge that takes a qualifying valid sample on channel c, and the change is visible on the following cycle.
- R8: `rd_level` shows the level from the last valid sample of channel `rd_sel`. It is updated on the cycle after that sample. It reads 0 when `rd_sel` is outside the channel range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thr_wr_hi | input | 1 | Stage `thr_byte` as the upper byte of the threshold field |
| thr_wr_lo | input | 1 | Commit the staged byte together with `thr_byte` to the selected threshold |
| thr_byte | input | 8 | Threshold byte data |
| thr_sel | input | 1 | Threshold target: 1 selects the low threshold, 0 selects the high threshold |
| run_len_m1 | input | RUN_W (8) | Required consecutive samples minus one |
| lvl_valid | input | NUM_CH (2) | Per-channel sample strobe |
| lvl_in | input | NUM_CH*16 | Level words; channel c occupies bits [16c+15:16c] |
| rd_sel | input | SEL_W (1) | Channel whose level appears on `rd_level` |
| rd_level | output | 16 | Last sampled level of the selected channel |
| mute_o | output | NUM_CH (2) | Per-channel mute flag, 1 = muted |

## Verification
The checker assumes the two threshold strobes are never asserted in the same cycle. It flags any cycle in which they are. Every stimulus task in the bench raises only one strobe for a single cycle, and level words are only given meaning when their valid bit is set. The mute-transition properties also assume the thresholds stay put between the qualifying sample and the flag change. The bench meets this because a threshold written in cycle t is only used by samples taken from cycle t+1 onward, which is the same timing the model uses.

// File: rtl/zl_mute_pkg.sv
// Shared definitions for the zero-level mute detector.
// Assumes the threshold field is always two bytes wide.
package zl_mute_pkg;
    localparam int THR_W  = 16;
    localparam int BYTE_W = 8;

    // Which threshold a committed write lands in (encoding of thr_sel).
    typedef enum logic {
        TGT_HIGH = 1'b0,
        TGT_LOW  = 1'b1
    } thr_tgt_e;

    typedef logic [THR_W-1:0] level_t;
endpackage

// File: rtl/zl_thr_regs.sv
// Threshold register pair with byte staging.
// The upper byte is held in a staging register. The full 16-bit value is
// committed to the target chosen by sel when the lower byte arrives.
// Assumes wr_hi and wr_lo are never asserted together.
module zl_thr_regs
    import zl_mute_pkg::*;
#(
    parameter level_t LO_RST = 16'h0100,
    parameter level_t HI_RST = 16'h0200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              sel,
    output level_t            thr_lo,
    output level_t            thr_hi
);
    logic [BYTE_W-1:0] stage_q;
    level_t            lo_q;
    level_t            hi_q;
    level_t            commit_val;
    thr_tgt_e          tgt;

    assign tgt        = thr_tgt_e'(sel);
    assign commit_val = {stage_q, wdata};

    // Hold the pending upper byte until the commit write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage_q <= '0;
        else if (wr_hi)
            stage_q <= wdata;
    end

    // Commit the assembled word to the selected threshold on a low-byte write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= LO_RST;
            hi_q <= HI_RST;
        end else if (wr_lo) begin
            if (tgt == TGT_LOW)
                lo_q <= commit_val;
            else
                hi_q <= commit_val;
        end
    end

    assign thr_lo = lo_q;
    assign thr_hi = hi_q;
endmodule

// File: rtl/zl_run_cnt.sv
// Consecutive-sample run counter.
// On each step it counts hits and raises fire on the step whose hit
// completes limit+1 consecutive hits. A miss clears the count, and so does
// a fire. With no step the count holds.
module zl_run_cnt #(
    parameter int RUN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             hit,
    input  logic [RUN_W-1:0] limit,
    output logic             fire
);
    logic [RUN_W-1:0] cnt_q;

    // Fire when this hit completes the run; >= guards a limit lowered mid-run.
    assign fire = step && hit && (cnt_q >= limit);

    // Advance, clear or hold the run length.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (step) begin
            if (!hit || fire)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/zl_chan.sv
// One channel of the mute detector: holds the last level sample and the
// mute state, and applies hysteresis through a run counter.
// Starts muted. It unmutes above thr_hi and mutes below thr_lo; both
// comparisons are strict.
module zl_chan
    import zl_mute_pkg::*;
#(
    parameter int RUN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  level_t           smp_level,
    input  level_t           thr_lo,
    input  level_t           thr_hi,
    input  logic [RUN_W-1:0] run_len_m1,
    output level_t           level_q,
    output logic             muted
);
    logic   muted_q;
    logic   want_flip;
    logic   flip;
    level_t lvl_q;

    // Condition that would move the channel to its other state.
    always_comb begin
        if (muted_q)
            want_flip = (smp_level > thr_hi);
        else
            want_flip = (smp_level < thr_lo);
    end

    zl_run_cnt #(.RUN_W(RUN_W)) u_run (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (smp_valid),
        .hit   (want_flip),
        .limit (run_len_m1),
        .fire  (flip)
    );

    // Toggle the mute state when the run completes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            muted_q <= 1'b1;
        else if (flip)
            muted_q <= ~muted_q;
    end

    // Capture the latest level sample for readback.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lvl_q <= '0;
        else if (smp_valid)
            lvl_q <= smp_level;
    end

    assign muted   = muted_q;
    assign level_q = lvl_q;
endmodule

// File: rtl/zl_mute_det.sv
// Top of the RMS zero-level mute detector.
// NUM_CH independent channels share one pair of hysteresis thresholds,
// which are loaded as two bytes. A level readback mux is provided.
// Assumes thr_wr_hi and thr_wr_lo are mutually exclusive.
module zl_mute_det
    import zl_mute_pkg::*;
#(
    parameter int     NUM_CH     = 2,
    parameter int     RUN_W      = 8,
    parameter level_t THR_LO_RST = 16'h0100,
    parameter level_t THR_HI_RST = 16'h0200,
    localparam int    SEL_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    thr_wr_hi,
    input  logic                    thr_wr_lo,
    input  logic [BYTE_W-1:0]       thr_byte,
    input  logic                    thr_sel,
    input  logic [RUN_W-1:0]        run_len_m1,
    input  logic [NUM_CH-1:0]       lvl_valid,
    input  logic [NUM_CH*THR_W-1:0] lvl_in,
    input  logic [SEL_W-1:0]        rd_sel,
    output logic [THR_W-1:0]        rd_level,
    output logic [NUM_CH-1:0]       mute_o
);
    level_t thr_lo_q;
    level_t thr_hi_q;
    level_t ch_level [NUM_CH];

    zl_thr_regs #(.LO_RST(THR_LO_RST), .HI_RST(THR_HI_RST)) u_thr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hi  (thr_wr_hi),
        .wr_lo  (thr_wr_lo),
        .wdata  (thr_byte),
        .sel    (thr_sel),
        .thr_lo (thr_lo_q),
        .thr_hi (thr_hi_q)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        zl_chan #(.RUN_W(RUN_W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .smp_valid  (lvl_valid[c]),
            .smp_level  (lvl_in[c*THR_W +: THR_W]),
            .thr_lo     (thr_lo_q),
            .thr_hi     (thr_hi_q),
            .run_len_m1 (run_len_m1),
            .level_q    (ch_level[c]),
            .muted      (mute_o[c])
        );
    end

    // Select the stored level of one channel; out of range reads zero.
    always_comb begin
        rd_level = '0;
        for (int c = 0; c < NUM_CH; c++)
            if (rd_sel == SEL_W'(c))
                rd_level = ch_level[c];
    end
endmodule

// File: rtl/zl_mute_det_chk.sv
// Property checker for zl_mute_det, bound to the top with access to the
// committed thresholds. Assumes exclusive threshold strobes.
module zl_mute_det_chk #(
    parameter int NUM_CH = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 thr_wr_hi,
    input logic                 thr_wr_lo,
    input logic                 thr_sel,
    input logic [NUM_CH-1:0]    lvl_valid,
    input logic [NUM_CH*16-1:0] lvl_in,
    input logic [NUM_CH-1:0]    mute_o,
    input logic [15:0]          thr_lo,
    input logic [15:0]          thr_hi
);
    // Input assumption on the strobes (R3).
    a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(thr_wr_hi && thr_wr_lo));

    // R1: all channels muted after a reset cycle.
    a_r1_reset_muted: assert property (@(posedge clk)
        !rst_n |=> (&mute_o));

    // R2 / R3: thresholds move only on a low-byte commit aimed at them.
    a_r2_lo_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_lo != $past(thr_lo)) |-> $past(thr_wr_lo && thr_sel));
    a_r3_hi_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_hi != $past(thr_hi)) |-> $past(thr_wr_lo && !thr_sel));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_c
        // R7: a flag change follows a valid sample on the same channel.
        a_r7_change_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
            (mute_o[c] != $past(mute_o[c])) |-> $past(lvl_valid[c]));
        // R4: muting follows a sample strictly below the low threshold.
        a_r4_mute_below_lo: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(mute_o[c]) |-> ($past(lvl_in[c*16 +: 16]) < $past(thr_lo)));
        // R5: unmuting follows a sample strictly above the high threshold.
        a_r5_unmute_above_hi: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(mute_o[c]) |-> ($past(lvl_in[c*16 +: 16]) > $past(thr_hi)));
    end
endmodule

bind zl_mute_det zl_mute_det_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .thr_wr_hi (thr_wr_hi),
    .thr_wr_lo (thr_wr_lo),
    .thr_sel   (thr_sel),
    .lvl_valid (lvl_valid),
    .lvl_in    (lvl_in),
    .mute_o    (mute_o),
    .thr_lo    (thr_lo_q),
    .thr_hi    (thr_hi_q)
);

// File: tb/sim_zl_mute_det.sv
`timescale 1ns/1ps
module sim_zl_mute_det;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        thr_wr_hi = 1'b0;
    logic        thr_wr_lo = 1'b0;
    logic [7:0]  thr_byte = '0;
    logic        thr_sel = 1'b0;
    logic [7:0]  run_len_m1 = '0;
    logic [1:0]  lvl_valid = '0;
    logic [31:0] lvl_in = '0;
    logic [0:0]  rd_sel = '0;
    logic [15:0] rd_level;
    logic [1:0]  mute_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    zl_mute_det u0 (
        .clk(clk), .rst_n(rst_n), .thr_wr_hi(thr_wr_hi), .thr_wr_lo(thr_wr_lo),
        .thr_byte(thr_byte), .thr_sel(thr_sel), .run_len_m1(run_len_m1),
        .lvl_valid(lvl_valid), .lvl_in(lvl_in), .rd_sel(rd_sel),
        .rd_level(rd_level), .mute_o(mute_o)
    );

    // Behavioural reference: integers per channel, evaluated at each edge.
    int m_lo, m_hi, m_stage;
    int m_cnt [2];
    int m_lvl [2];
    bit m_mute [2];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lo = 256; m_hi = 512; m_stage = 0;
            for (int c = 0; c < 2; c++) begin m_cnt[c] = 0; m_lvl[c] = 0; m_mute[c] = 1; end
        end else begin
            for (int c = 0; c < 2; c++) begin
                if (lvl_valid[c]) begin
                    int v;
                    bit cond;
                    v = int'(lvl_in[c*16 +: 16]);
                    m_lvl[c] = v;
                    cond = m_mute[c] ? (v > m_hi) : (v < m_lo);
                    if (!cond) m_cnt[c] = 0;
                    else if (m_cnt[c] + 1 >= int'(run_len_m1) + 1) begin
                        m_cnt[c] = 0; m_mute[c] = !m_mute[c];
                    end else m_cnt[c] = m_cnt[c] + 1;
                end
            end
            if (thr_wr_lo) begin
                if (thr_sel) m_lo = m_stage * 256 + int'(thr_byte);
                else         m_hi = m_stage * 256 + int'(thr_byte);
            end
            if (thr_wr_hi) m_stage = int'(thr_byte);
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison with the reference, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R7 mute vs model", int'(mute_o), {m_mute[1], m_mute[0]});
            chk("R8 readback vs model", int'(rd_level), m_lvl[rd_sel]);
        end
    end

    task automatic smp(input logic [1:0] v, input logic [15:0] l0, input logic [15:0] l1);
        lvl_valid = v; lvl_in = {l1, l0};
        @(posedge clk); #1;
        lvl_valid = '0;
    endtask

    task automatic whi(input logic [7:0] b);
        thr_wr_hi = 1'b1; thr_byte = b;
        @(posedge clk); #1;
        thr_wr_hi = 1'b0;
    endtask

    task automatic wlo(input logic s, input logic [7:0] b);
        thr_wr_lo = 1'b1; thr_sel = s; thr_byte = b;
        @(posedge clk); #1;
        thr_wr_lo = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        chk("R1 reset mute", int'(mute_o), 3);
        chk("R1 reset level", int'(rd_level), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 mute after reset", int'(mute_o), 3);

        // Single-sample transitions with strict comparisons.
        smp(2'b11, 16'h0300, 16'h0200);
        chk("R5 unmute above hi, equal stays muted", int'(mute_o), 2);
        smp(2'b01, 16'h0100, 16'h0000);
        chk("R4 equal to lo keeps unmuted", int'(mute_o), 2);
        smp(2'b01, 16'h00FF, 16'h0000);
        chk("R4 below lo mutes", int'(mute_o), 3);

        // Staged upper byte must not take effect.
        whi(8'h01);
        smp(2'b01, 16'h0180, 16'h0000);
        chk("R2 staged byte unused", int'(mute_o), 3);
        wlo(1'b0, 8'h00);
        smp(2'b01, 16'h0180, 16'h0000);
        chk("R3 hi threshold committed", int'(mute_o), 2);
        whi(8'h10); wlo(1'b1, 8'h00);
        smp(2'b01, 16'h0FFF, 16'h0000);
        chk("R3 lo threshold committed", int'(mute_o), 3);
        whi(8'h01); wlo(1'b1, 8'h00);
        whi(8'h02); wlo(1'b0, 8'h00);

        rd_sel = 1'b0; #1;
        chk("R8 readback ch0", int'(rd_level), 16'h0FFF);
        rd_sel = 1'b1; #1;
        chk("R8 readback ch1", int'(rd_level), 16'h0200);

        // Run length of three samples.
        run_len_m1 = 8'd2;
        smp(2'b10, 16'h0, 16'h0300);
        smp(2'b10, 16'h0, 16'h0300);
        chk("R5 two of three samples", int'(mute_o), 3);
        smp(2'b10, 16'h0, 16'h0300);
        chk("R5 third sample unmutes", int'(mute_o), 1);
        smp(2'b10, 16'h0, 16'h0050);
        smp(2'b10, 16'h0, 16'h0050);
        smp(2'b10, 16'h0, 16'h0150);
        smp(2'b10, 16'h0, 16'h0050);
        repeat (3) @(posedge clk);
        #1;
        smp(2'b10, 16'h0, 16'h0050);
        chk("R6 miss restarts run", int'(mute_o), 1);
        smp(2'b10, 16'h0, 16'h0050);
        chk("R6 new run completes", int'(mute_o), 3);

        // Longest run: 256 samples.
        run_len_m1 = 8'd0;
        smp(2'b01, 16'h0300, 16'h0);
        chk("R7 ch0 alone unmutes", int'(mute_o), 2);
        run_len_m1 = 8'd255;
        for (int i = 0; i < 255; i++) smp(2'b01, 16'h0010, 16'h0);
        chk("R4 255 samples insufficient", int'(mute_o), 2);
        smp(2'b01, 16'h0010, 16'h0);
        chk("R4 256th sample mutes", int'(mute_o), 3);

        // Mixed traffic compared against the model every cycle.
        run_len_m1 = 8'd1;
        for (int i = 0; i < 600; i++) begin
            logic [15:0] pick [5];
            pick = '{16'h0050, 16'h0100, 16'h0150, 16'h0200, 16'h0250};
            rd_sel = 1'($urandom_range(0, 1));
            smp(2'($urandom_range(0, 3)), pick[$urandom_range(0, 4)], pick[$urandom_range(0, 4)]);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule